// File: doc/BRIEF.md
# Reed-Solomon RS(528,514) Systematic Parity Encoder

This block turns a stream of 10-bit symbols into systematic Reed-Solomon codewords over GF(2^10). The field is built on the primitive polynomial x^10 + x^3 + 1. A codeword starts with a symbol flagged by a start strobe. The block takes 514 message symbols, one per accepted cycle, and forwards each one unchanged one cycle later. It then appends 14 parity symbols, which makes a 528-symbol codeword that a decoder can check against the 14 consecutive roots alpha^0 to alpha^13.

The input side is valid/ready. A symbol moves on a clock edge where `s_valid` and `s_ready` are both high. The source may leave gaps by lowering `s_valid` within a message; the block simply waits. The block drops `s_ready` for the 14 cycles in which it drains the parity, so the source must hold its next symbol until `s_ready` returns. The output side has no back-pressure: a symbol is presented for exactly one cycle with `m_valid`, and `m_parity` marks the parity part. The remainder state lives in a 14-stage shift register with fixed field multipliers, whose constants the code derives from the field polynomial when it elaborates.

Top module: `rs_parity_encoder`

## Requirements
- R1: After reset `m_valid` and `m_parity` are 0 and `s_ready` is 1.
- R2: Each accepted message symbol appears on `m_sym` one cycle after acceptance, unchanged, with `m_valid`=1 and `m_parity`=0.
- R3: After the 514th message symbol, exactly 14 symbols follow with `m_valid`=1 and `m_parity`=1. They come in consecutive cycles, and the first one comes in the cycle after the last message symbol leaves.
- R4: The 528 output symbols, with the first one out taken as the coefficient of x^527, form a polynomial that is zero at alpha^i for i = 0..13. Here alpha is a root of x^10+x^3+1 in GF(2^10), and symbol bit k is the coefficient of alpha^k.
- R5: `s_ready` is 0 in exactly the 14 cycles of parity output generation and 1 at all other times.
- R6: Cycles with `s_valid`=0 inside a message produce no output and do not disturb the codeword.
- R7: An accepted `s_sof`=1 in the middle of a message abandons that message. The symbol that carries the strobe becomes symbol 0 of a new codeword, and the parity covers only the new message.
- R8: Symbols accepted with `s_sof`=0 while no codeword is open are discarded and produce no output.
- R9: A new codeword may start in the first cycle `s_ready` returns. Its output then follows the previous parity with no idle cycle.
- R10: An all-zero message yields 14 all-zero parity symbols.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| s_valid | input | 1 | Input symbol valid |
| s_ready | output | 1 | Encoder can accept a symbol |
| s_sof | input | 1 | Symbol is the first of a codeword |
| s_sym | input | 10 | Input message symbol |
| m_valid | output | 1 | Output symbol valid |
| m_parity | output | 1 | Output symbol is a parity symbol |
| m_sym | output | 10 | Output codeword symbol |

## Verification
Two things can fall on the same clock edge: clearing the remainder register for a new codeword, and absorbing that codeword's first symbol into the feedback. A start strobe mid-message provokes this, and so does a new codeword accepted the moment `s_ready` returns after a parity drain. The result is judged by evaluating the following codeword at all 14 roots with field tables the bench builds itself. Any stale remainder that leaked through would leave a non-zero syndrome. Output cycle numbers are also compared, so that the back-to-back case shows no idle gap and no overlap.

// File: rtl/rs_gf_pkg.sv
package rs_gf_pkg;
  localparam int SYM_W = 10;
  localparam logic [SYM_W:0] FIELD_POLY = 11'h409;
  localparam int MAX_PAR = 32;

  typedef logic [SYM_W-1:0] sym_t;
  typedef enum logic [1:0] {PH_IDLE = 2'd0, PH_MSG = 2'd1, PH_PAR = 2'd2} phase_e;

  // multiply by alpha, reducing modulo the field polynomial
  function automatic sym_t gf_xtime(input sym_t a);
    sym_t r;
    r = {a[SYM_W-2:0], 1'b0};
    if (a[SYM_W-1]) r = r ^ FIELD_POLY[SYM_W-1:0];
    return r;
  endfunction

  function automatic sym_t gf_mul(input sym_t a, input sym_t b);
    sym_t r;
    r = '0;
    for (int i = SYM_W - 1; i >= 0; i--) begin
      r = gf_xtime(r);
      if (b[i]) r = r ^ a;
    end
    return r;
  endfunction

  // coefficient idx of prod_{i<npar} (x + alpha^i); leading term is implicit
  function automatic sym_t gen_coef(input int idx, input int npar);
    sym_t g [0:MAX_PAR];
    sym_t root;
    for (int j = 0; j <= MAX_PAR; j++) g[j] = '0;
    g[0] = sym_t'(1);
    root = sym_t'(1);
    for (int i = 0; i < npar; i++) begin
      for (int j = i + 1; j > 0; j--) g[j] = g[j-1] ^ gf_mul(g[j], root);
      g[0] = gf_mul(g[0], root);
      root = gf_xtime(root);
    end
    return g[idx];
  endfunction
endpackage

// File: rtl/rs_gf_cmul.sv
module rs_gf_cmul
  import rs_gf_pkg::*;
#(
  parameter sym_t COEF = '0
) (
  input  sym_t a,
  output sym_t y
);
  // constant operand folds into a fixed XOR network
  assign y = gf_mul(a, COEF);
endmodule

// File: rtl/rs_enc_lfsr.sv
module rs_enc_lfsr
  import rs_gf_pkg::*;
#(
  parameter int NPAR = 14
) (
  input  logic clk,
  input  logic rst_n,
  input  logic absorb,
  input  logic restart,
  input  logic drain,
  input  sym_t din,
  output sym_t top
);
  sym_t rem  [NPAR];
  sym_t nxt  [NPAR];
  sym_t prod [NPAR];
  sym_t fb;

  // a restart treats the remainder as already cleared
  assign fb = absorb ? (din ^ (restart ? '0 : rem[NPAR-1])) : '0;

  for (genvar i = 0; i < NPAR; i++) begin : g_tap
    localparam sym_t TAP = gen_coef(i, NPAR);
    rs_gf_cmul #(.COEF(TAP)) u_mul (.a(fb), .y(prod[i]));
  end

  always_comb begin
    sym_t up;
    for (int i = 0; i < NPAR; i++) begin
      up = (i == 0) ? '0 : rem[(i == 0) ? 0 : i - 1];
      if (absorb)     nxt[i] = (restart ? '0 : up) ^ prod[i];
      else if (drain) nxt[i] = up;
      else            nxt[i] = rem[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NPAR; i++) rem[i] <= '0;
    end else begin
      for (int i = 0; i < NPAR; i++) rem[i] <= nxt[i];
    end
  end

  assign top = rem[NPAR-1];

  // a drain must never coincide with absorbing input
  AST_DRAIN_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    drain |-> !absorb);  // R5
endmodule

// File: rtl/rs_enc_ctrl.sv
module rs_enc_ctrl
  import rs_gf_pkg::*;
#(
  parameter int MSG_LEN = 514,
  parameter int PAR_LEN = 14
) (
  input  logic clk,
  input  logic rst_n,
  input  logic s_valid,
  input  logic s_sof,
  output logic s_ready,
  output logic absorb,
  output logic restart,
  output logic drain,
  output logic in_idle,
  output logic in_msg
);
  localparam int SPAN  = (MSG_LEN > PAR_LEN) ? MSG_LEN : PAR_LEN;
  localparam int CNT_W = $clog2(SPAN + 1);

  phase_e           ph;
  logic [CNT_W-1:0] cnt;
  logic             take;

  assign s_ready = (ph != PH_PAR);
  assign take    = s_valid & s_ready;
  assign restart = take & s_sof;
  assign absorb  = restart | (take & (ph == PH_MSG));
  assign drain   = (ph == PH_PAR);
  assign in_idle = (ph == PH_IDLE);
  assign in_msg  = (ph == PH_MSG);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph  <= PH_IDLE;
      cnt <= '0;
    end else if (restart) begin
      if (MSG_LEN == 1) begin
        ph  <= PH_PAR;
        cnt <= '0;
      end else begin
        ph  <= PH_MSG;
        cnt <= CNT_W'(1);
      end
    end else begin
      case (ph)
        PH_MSG: if (absorb) begin
          if (cnt == CNT_W'(MSG_LEN - 1)) begin
            ph  <= PH_PAR;
            cnt <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        PH_PAR: begin
          if (cnt == CNT_W'(PAR_LEN - 1)) begin
            ph  <= PH_IDLE;
            cnt <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  AST_MSG_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_MSG) |-> (cnt < CNT_W'(MSG_LEN)));  // R3
endmodule

// File: rtl/rs_parity_encoder.sv
module rs_parity_encoder
  import rs_gf_pkg::*;
#(
  parameter int MSG_LEN = 514,
  parameter int PAR_LEN = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             s_valid,
  output logic             s_ready,
  input  logic             s_sof,
  input  logic [SYM_W-1:0] s_sym,
  output logic             m_valid,
  output logic             m_parity,
  output logic [SYM_W-1:0] m_sym
);
  localparam int RUN_W = $clog2(PAR_LEN + 1);

  logic absorb, restart, drain, in_idle, in_msg;
  sym_t rem_top;

  rs_enc_ctrl #(.MSG_LEN(MSG_LEN), .PAR_LEN(PAR_LEN)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_sof(s_sof),
    .s_ready(s_ready), .absorb(absorb), .restart(restart), .drain(drain),
    .in_idle(in_idle), .in_msg(in_msg)
  );

  rs_enc_lfsr #(.NPAR(PAR_LEN)) u_lfsr (
    .clk(clk), .rst_n(rst_n), .absorb(absorb), .restart(restart),
    .drain(drain), .din(s_sym), .top(rem_top)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_valid  <= 1'b0;
      m_parity <= 1'b0;
      m_sym    <= '0;
    end else begin
      m_valid  <= absorb | drain;
      m_parity <= drain;
      m_sym    <= absorb ? s_sym : (drain ? rem_top : '0);
    end
  end

  // length of the current parity run, for the checks below
  logic [RUN_W-1:0] par_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        par_run <= '0;
    else if (m_parity) par_run <= par_run + 1'b1;
    else               par_run <= '0;
  end

  AST_MSG_FORWARD: assert property (@(posedge clk) disable iff (!rst_n)
    $past(s_valid && s_ready && (s_sof || in_msg)) |->
      (m_valid && !m_parity && (m_sym == $past(s_sym))));  // R2
  AST_PARITY_NOT_LONG: assert property (@(posedge clk) disable iff (!rst_n)
    m_parity |-> (par_run < RUN_W'(PAR_LEN)));  // R3
  AST_PARITY_FULL_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(m_parity) |-> ($past(par_run) == RUN_W'(PAR_LEN - 1)));  // R3
  AST_STALL_IN_PARITY: assert property (@(posedge clk) disable iff (!rst_n)
    m_parity |-> !$past(s_ready));  // R5
  AST_READY_AFTER_PARITY: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(m_parity) |-> s_ready);  // R5
  AST_IDLE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (in_idle && !(s_valid && s_sof)) |=> !m_valid);  // R8
endmodule

// File: tb/test_rs_parity_encoder.sv
module test_rs_parity_encoder;
  localparam int CLK_PERIOD = 10;
  localparam int MSG = 514;
  localparam int PAR = 14;
  localparam int CW  = MSG + PAR;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       s_valid = 1'b0;
  logic       s_sof = 1'b0;
  logic [9:0] s_sym = '0;
  logic       s_ready, m_valid, m_parity;
  logic [9:0] m_sym;

  rs_parity_encoder #(.MSG_LEN(MSG), .PAR_LEN(PAR)) i_rs_parity_encoder (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
    .s_sof(s_sof), .s_sym(s_sym), .m_valid(m_valid), .m_parity(m_parity),
    .m_sym(m_sym)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;
  int unsigned rng = 32'h1234_5678;

  logic [9:0] exp_t [0:1022];
  int         log_t [0:1023];
  logic [9:0] sent    [0:2047];
  logic [9:0] cap_sym [0:2047];
  logic       cap_par [0:2047];
  int         cap_cyc [0:2047];
  int n_sent = 0, n_cap = 0, cyc = 0, ready_low = 0;

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (m_valid && n_cap < 2048) begin
        cap_sym[n_cap] = m_sym;
        cap_par[n_cap] = m_parity;
        cap_cyc[n_cap] = cyc;
        n_cap++;
      end
      if (!s_ready) ready_low++;
    end
  end

  function automatic logic [9:0] gmul(input logic [9:0] a, input logic [9:0] b);
    if (a == 0 || b == 0) return 10'd0;
    return exp_t[(log_t[a] + log_t[b]) % 1023];
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
    end
  endtask

  task automatic clear_log();
    n_cap = 0; n_sent = 0; ready_low = 0;
  endtask

  // called at a negedge; returns at the negedge after acceptance
  task automatic push(input logic [9:0] v, input bit sof);
    s_valid = 1'b1; s_sym = v; s_sof = sof;
    while (!s_ready) @(negedge clk);
    @(negedge clk);
    s_valid = 1'b0; s_sof = 1'b0;
  endtask

  function automatic logic [9:0] sym_for(input int mode, input int k, input int arg);
    case (mode)
      0: return 10'd0;
      1: return 10'h3FF;
      2: return 10'((k * 37 + arg) & 1023);
      3: begin rng = rng * 32'd1103515245 + 32'd12345; return rng[25:16]; end
      default: return (k == arg) ? 10'h2A5 : 10'd0;
    endcase
  endfunction

  task automatic send_msg(input int mode, input int arg, input bit gap, input int nsym);
    logic [9:0] v;
    for (int k = 0; k < nsym; k++) begin
      v = sym_for(mode, k, arg);
      sent[n_sent] = v; n_sent++;
      if (gap && (k % 7 == 3)) begin
        s_valid = 1'b0;
        repeat (1 + k % 2) @(negedge clk);
      end
      push(v, k == 0);
    end
  endtask

  // message match (R2), flags and timing (R3), roots (R4)
  task automatic check_cw(input int base, input int sbase);
    int bad_m, bad_p, bad_s, first_a, first_e;
    logic [9:0] s;
    bad_m = 0; bad_p = 0; bad_s = 0; first_a = 0; first_e = 0;
    for (int j = 0; j < MSG; j++)
      if (cap_sym[base+j] !== sent[sbase+j] || cap_par[base+j] !== 1'b0) begin
        if (bad_m == 0) begin first_a = cap_sym[base+j]; first_e = sent[sbase+j]; end
        bad_m++;
      end
    check(bad_m == 0, "R2 message symbol forwarded", first_a, first_e);
    for (int j = MSG; j < CW; j++)
      if (cap_par[base+j] !== 1'b1 || cap_cyc[base+j] != cap_cyc[base+j-1] + 1) bad_p++;
    check(bad_p == 0, "R3 parity flag and contiguity errors", bad_p, 0);
    for (int i = 0; i < PAR; i++) begin
      s = '0;
      for (int j = 0; j < CW; j++) s = gmul(s, exp_t[i]) ^ cap_sym[base+j];
      if (s != 0) bad_s++;
    end
    check(bad_s == 0, "R4 non-zero syndromes", bad_s, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog R3: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int v;
    int modes [8];
    int args  [8];
    v = 1;
    for (int k = 0; k < 1023; k++) begin
      exp_t[k] = 10'(v); log_t[v] = k;
      v = v << 1;
      if (v & 1024) v = v ^ 32'h409;
    end
    modes = '{0, 1, 2, 2, 3, 4, 4, 4};
    args  = '{0, 0, 5, 900, 0, 0, 257, 513};

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    check(m_valid == 1'b0, "R1 m_valid after reset", m_valid, 0);
    check(m_parity == 1'b0, "R1 m_parity after reset", m_parity, 0);
    check(s_ready == 1'b1, "R1 s_ready after reset", s_ready, 1);

    // R8: no open codeword, strobe-less symbols vanish
    clear_log();
    for (int k = 0; k < 5; k++) push(10'(341 + k), 1'b0);
    repeat (4) @(negedge clk);
    check(n_cap == 0, "R8 outputs from dropped symbols", n_cap, 0);

    // sweep of message patterns
    for (int t = 0; t < 8; t++) begin
      clear_log();
      send_msg(modes[t], args[t], 1'b0, MSG);
      repeat (20) @(negedge clk);
      check(n_cap == CW, "R3 codeword length", n_cap, CW);
      check_cw(0, 0);
      check(ready_low == PAR, "R5 ready-low cycles", ready_low, PAR);
      if (modes[t] == 0) begin
        int nz;
        nz = 0;
        for (int j = MSG; j < CW; j++) if (cap_sym[j] != 0) nz++;
        check(nz == 0, "R10 non-zero parity for zero message", nz, 0);
      end
    end

    // R6: valid gaps inside the message
    clear_log();
    send_msg(3, 0, 1'b1, MSG);
    repeat (20) @(negedge clk);
    check(n_cap == CW, "R6 length with input gaps", n_cap, CW);
    check_cw(0, 0);

    // R7: restart after 100 symbols
    clear_log();
    send_msg(2, 11, 1'b0, 100);
    send_msg(3, 0, 1'b0, MSG);
    repeat (20) @(negedge clk);
    check(n_cap == 100 + CW, "R7 length after abort", n_cap, 100 + CW);
    begin
      int bad;
      bad = 0;
      for (int j = 0; j < 100; j++) if (cap_sym[j] !== sent[j] || cap_par[j]) bad++;
      check(bad == 0, "R7 aborted prefix forwarded", bad, 0);
    end
    check_cw(100, 100);

    // R9: back-to-back codewords
    clear_log();
    send_msg(3, 0, 1'b0, MSG);
    send_msg(1, 0, 1'b0, MSG);
    repeat (20) @(negedge clk);
    check(n_cap == 2 * CW, "R9 length of two codewords", n_cap, 2 * CW);
    check_cw(0, 0);
    check_cw(CW, MSG);
    check(cap_cyc[CW] == cap_cyc[CW-1] + 1, "R9 gap between codewords",
          cap_cyc[CW] - cap_cyc[CW-1], 1);
    check(ready_low == 2 * PAR, "R5 ready-low cycles back-to-back", ready_low, 2 * PAR);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule